// File: doc/BRIEF.md
# Out-of-Order Memory Dispatch Selector

This block holds a small circular reorder buffer of in-flight instructions. Each cycle it picks at most one load or store that may safely go to memory ahead of program order. Each slot records an instruction class, resolution flags for its address (or, for a branch, its condition) and its store data, the address and data values, and a flag set once the access has been sent.

An entry qualifies when its own operands are known and nothing older stands in the way. A younger access must wait behind an older branch whose outcome is still open, behind an older load without an address, or behind an older store missing its address or data. It also waits behind an older same-address access that has not yet been sent, where that access would make the reordering unsafe. Among the entries that qualify, the oldest relative to the head wins. The request is presented on a valid/ready pair, and the slot is marked as sent when the downstream side accepts it.

Slots are filled at the tail through an allocate port, operands are filled in through a resolve port addressed by slot index, and the head slot is released through a pop input.

Top module: `mem_dispatch_sel`

## Requirements
- R1: After reset the buffer is empty, `mem_valid` is low and `alloc_ready` is high.
- R2: No access is offered while any older branch entry (class code 1) has its resolved flag clear. For a branch, a resolve with `res_addr_en` high sets that flag.
- R3: No access younger than a load whose address is unresolved is offered.
- R4: No access younger than a store whose address or data is unresolved is offered.
- R5: A load is never offered ahead of an older same-address store that has not been sent.
- R6: A store is never offered ahead of an older same-address load or store that has not been sent.
- R7: A load is offered only with its own address resolved. A store is offered only with both its address and its data resolved.
- R8: Class codes are 0 other, 2 load and 3 store. The request gives the slot index in `mem_idx`, sets `mem_is_store` high only for a store, gives the address in `mem_addr` and, for a store, the data in `mem_data`.
- R9: When several entries qualify, the oldest counted from the head is offered, even after the pointers wrap. At most one access is accepted per cycle, and no sent entry is offered again.
- R10: While `mem_ready` is low, the oldest eligible entry stays on the request outputs and no entry is marked as sent.
- R11: The selection uses the state held at the start of the cycle. A resolve that arrives in a cycle takes effect on the request outputs from the next cycle. An accepted access is withdrawn in the next cycle.
- R12: With all slots occupied, `alloc_ready` is low and an allocate request changes nothing. The next allocate after a pop uses the slot that follows the last filled one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Append an entry at the tail |
| alloc_kind | input | 2 | Class: 0 other, 1 branch, 2 load, 3 store |
| alloc_addr_ok | input | 1 | Address (or branch outcome) already known |
| alloc_addr | input | AW | Address value |
| alloc_data_ok | input | 1 | Store data already known |
| alloc_data | input | DW | Store data value |
| alloc_ready | output | 1 | A slot is free |
| res_valid | input | 1 | Fill operands of slot `res_idx` |
| res_idx | input | IW | Slot index to update |
| res_addr_en | input | 1 | Set address-known flag and value (branch: outcome known) |
| res_addr | input | AW | Resolved address |
| res_data_en | input | 1 | Set data-known flag and value |
| res_data | input | DW | Resolved data |
| pop | input | 1 | Release the head slot |
| mem_ready | input | 1 | Downstream accepts a request |
| mem_valid | output | 1 | A request is offered |
| mem_idx | output | IW | Slot index of the offered entry |
| mem_is_store | output | 1 | Offered entry is a store |
| mem_addr | output | AW | Request address |
| mem_data | output | DW | Store data (zero for loads) |

## Verification
The pair of functions that can land in one cycle is operand resolution for an older blocker and selection of a younger access. The bench resolves a pending branch in the same cycle that it raises `mem_ready` with a younger ready load behind it. It then requires the request to stay low in that cycle and the load to appear, and be accepted, in the next one. A scoreboard queue holds the accesses expected in order, so any early, late, duplicated or reordered acceptance shows up as a mismatch or as an unexpected item.

// File: rtl/mds_pkg.sv
// Shared types for the memory dispatch selector.
package mds_pkg;
    // Instruction class held in every buffer slot
    typedef enum logic [1:0] {
        K_OTHER  = 2'd0,
        K_BRANCH = 2'd1,
        K_LOAD   = 2'd2,
        K_STORE  = 2'd3
    } kind_e;
endpackage

// File: rtl/mds_rob_store.sv
// Circular slot storage with head/tail pointers.
// Does: allocate at tail, release at head, fill operands by index,
// mark a slot as sent. Assumes DEPTH is a power of two so pointers wrap
// by truncation; pop on an empty buffer and allocate when full are ignored.
module mds_rob_store
    import mds_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  kind_e            alloc_kind,
    input  logic             alloc_addr_ok,
    input  logic [AW-1:0]    alloc_addr,
    input  logic             alloc_data_ok,
    input  logic [DW-1:0]    alloc_data,
    output logic             alloc_ready,
    input  logic             res_valid,
    input  logic [IW-1:0]    res_idx,
    input  logic             res_addr_en,
    input  logic [AW-1:0]    res_addr,
    input  logic             res_data_en,
    input  logic [DW-1:0]    res_data,
    input  logic             pop,
    input  logic             sent_fire,
    input  logic [IW-1:0]    sent_idx,
    output logic [IW-1:0]    head_o,
    output logic [IW:0]      count_o,
    output logic [DEPTH-1:0] valid_o,
    output logic [DEPTH-1:0] aok_o,
    output logic [DEPTH-1:0] dok_o,
    output logic [DEPTH-1:0] sent_o,
    output kind_e            kind_o [DEPTH],
    output logic [AW-1:0]    addr_o [DEPTH],
    output logic [DW-1:0]    data_o [DEPTH]
);
    typedef struct packed {
        logic          valid;
        logic          aok;
        logic          dok;
        logic          sent;
        kind_e         kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } slot_t;

    slot_t         slot_q [DEPTH];
    logic [IW-1:0] head_q, tail_q;
    logic [IW:0]   count_q;
    logic          full, do_alloc, do_pop;

    // Handshake decode for the allocate and release ports
    always_comb begin
        full     = (count_q == (IW+1)'(DEPTH));
        do_alloc = alloc_valid && !full;
        do_pop   = pop && (count_q != '0);
    end

    assign alloc_ready = !full;
    assign head_o      = head_q;
    assign count_o     = count_q;

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (do_pop)   head_q <= head_q + 1'b1;
            if (do_alloc) tail_q <= tail_q + 1'b1;
            case ({do_alloc, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Per-slot state: fill on allocate, otherwise release/resolve/mark
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[i] <= '{valid: 1'b0, aok: 1'b0, dok: 1'b0, sent: 1'b0,
                               kind: K_OTHER, addr: '0, data: '0};
            end else if (do_alloc && tail_q == IW'(i)) begin
                slot_q[i] <= '{valid: 1'b1, aok: alloc_addr_ok,
                               dok: alloc_data_ok, sent: 1'b0,
                               kind: alloc_kind, addr: alloc_addr,
                               data: alloc_data};
            end else begin
                if (do_pop && head_q == IW'(i))
                    slot_q[i].valid <= 1'b0;
                if (res_valid && res_idx == IW'(i) && slot_q[i].valid) begin
                    if (res_addr_en) begin
                        slot_q[i].aok  <= 1'b1;
                        slot_q[i].addr <= res_addr;
                    end
                    if (res_data_en) begin
                        slot_q[i].dok  <= 1'b1;
                        slot_q[i].data <= res_data;
                    end
                end
                if (sent_fire && sent_idx == IW'(i))
                    slot_q[i].sent <= 1'b1;
            end
        end

        // Flatten slot fields onto the scan-facing outputs
        always_comb begin
            valid_o[i] = slot_q[i].valid;
            aok_o[i]   = slot_q[i].aok;
            dok_o[i]   = slot_q[i].dok;
            sent_o[i]  = slot_q[i].sent;
            kind_o[i]  = slot_q[i].kind;
            addr_o[i]  = slot_q[i].addr;
            data_o[i]  = slot_q[i].data;
        end
    end
endmodule

// File: rtl/mds_age_scan.sv
// Age-ordered eligibility scan.
// Does: walks slots from the head (oldest) to the youngest, tracks whether
// anything older is still unresolved, checks same-address hazards against
// older unsent accesses, and picks the oldest eligible load or store.
// Assumes DEPTH is a power of two; invalid slots are skipped.
module mds_age_scan
    import mds_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic [IW-1:0]    head,
    input  logic [DEPTH-1:0] valid,
    input  logic [DEPTH-1:0] aok,
    input  logic [DEPTH-1:0] dok,
    input  logic [DEPTH-1:0] sent,
    input  kind_e            kind [DEPTH],
    input  logic [AW-1:0]    addr [DEPTH],
    output logic             found,
    output logic [IW-1:0]    sel_idx
);
    logic [IW-1:0]    ix [DEPTH];
    logic [DEPTH-1:0] stall_src, gate_blk, own_ok, hazard, elig;

    // Map age position to slot index, and classify each position
    always_comb begin
        for (int p = 0; p < DEPTH; p++) begin
            ix[p] = head + IW'(p);
            stall_src[p] = valid[ix[p]] && (
                (kind[ix[p]] == K_BRANCH && !aok[ix[p]]) ||
                (kind[ix[p]] == K_LOAD   && !aok[ix[p]]) ||
                (kind[ix[p]] == K_STORE  && !(aok[ix[p]] && dok[ix[p]])));
            own_ok[p] = valid[ix[p]] && !sent[ix[p]] && aok[ix[p]] &&
                ((kind[ix[p]] == K_LOAD) ||
                 (kind[ix[p]] == K_STORE && dok[ix[p]]));
        end
    end

    // Prefix OR: any older unresolved entry gates this position
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int p = 0; p < DEPTH; p++) begin
            gate_blk[p] = acc;
            acc = acc | stall_src[p];
        end
    end

    // Same-address hazards against older unsent accesses
    always_comb begin
        for (int p = 0; p < DEPTH; p++) begin
            hazard[p] = 1'b0;
            for (int q = 0; q < DEPTH; q++) begin
                if (q < p && valid[ix[q]] && !sent[ix[q]] &&
                    addr[ix[q]] == addr[ix[p]] &&
                    (kind[ix[q]] == K_STORE ||
                     (kind[ix[q]] == K_LOAD && kind[ix[p]] == K_STORE)))
                    hazard[p] = 1'b1;
            end
        end
    end

    // Oldest eligible position wins
    always_comb begin
        elig    = own_ok & ~gate_blk & ~hazard;
        found   = |elig;
        sel_idx = '0;
        for (int p = DEPTH - 1; p >= 0; p--) begin
            if (elig[p]) sel_idx = ix[p];
        end
    end
endmodule

// File: rtl/mem_dispatch_sel.sv
// Top of the memory dispatch selector.
// Does: ties slot storage to the age scan, drives the request outputs and
// marks the chosen slot as sent on valid && ready. Assumes the consumer
// samples requests on the rising edge and the producer pops only
// entries it is finished with.
module mem_dispatch_sel
    import mds_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic [1:0]    alloc_kind,
    input  logic          alloc_addr_ok,
    input  logic [AW-1:0] alloc_addr,
    input  logic          alloc_data_ok,
    input  logic [DW-1:0] alloc_data,
    output logic          alloc_ready,
    input  logic          res_valid,
    input  logic [IW-1:0] res_idx,
    input  logic          res_addr_en,
    input  logic [AW-1:0] res_addr,
    input  logic          res_data_en,
    input  logic [DW-1:0] res_data,
    input  logic          pop,
    input  logic          mem_ready,
    output logic          mem_valid,
    output logic [IW-1:0] mem_idx,
    output logic          mem_is_store,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data
);
    logic [IW-1:0]    head;
    logic [IW:0]      count;
    logic [DEPTH-1:0] valid_v, aok_v, dok_v, sent_v;
    kind_e            kind_a [DEPTH];
    logic [AW-1:0]    addr_a [DEPTH];
    logic [DW-1:0]    data_a [DEPTH];
    logic             found, fire;
    logic [IW-1:0]    sel;

    mds_rob_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_valid  (alloc_valid),
        .alloc_kind   (kind_e'(alloc_kind)),
        .alloc_addr_ok(alloc_addr_ok),
        .alloc_addr   (alloc_addr),
        .alloc_data_ok(alloc_data_ok),
        .alloc_data   (alloc_data),
        .alloc_ready  (alloc_ready),
        .res_valid    (res_valid),
        .res_idx      (res_idx),
        .res_addr_en  (res_addr_en),
        .res_addr     (res_addr),
        .res_data_en  (res_data_en),
        .res_data     (res_data),
        .pop          (pop),
        .sent_fire    (fire),
        .sent_idx     (sel),
        .head_o       (head),
        .count_o      (count),
        .valid_o      (valid_v),
        .aok_o        (aok_v),
        .dok_o        (dok_v),
        .sent_o       (sent_v),
        .kind_o       (kind_a),
        .addr_o       (addr_a),
        .data_o       (data_a)
    );

    mds_age_scan #(.DEPTH(DEPTH), .AW(AW)) u_scan (
        .head   (head),
        .valid  (valid_v),
        .aok    (aok_v),
        .dok    (dok_v),
        .sent   (sent_v),
        .kind   (kind_a),
        .addr   (addr_a),
        .found  (found),
        .sel_idx(sel)
    );

    // Request outputs and acceptance strobe
    always_comb begin
        fire         = found && mem_ready;
        mem_valid    = found;
        mem_idx      = sel;
        mem_is_store = (kind_a[sel] == K_STORE);
        mem_addr     = addr_a[sel];
        mem_data     = mem_is_store ? data_a[sel] : '0;
    end
endmodule

// File: rtl/mds_chk.sv
// Property checker for the memory dispatch selector, bound to the top.
module mds_chk #(
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             alloc_ready,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic [IW-1:0]    mem_idx,
    input logic             mem_is_store,
    input logic [IW:0]      count,
    input logic [DEPTH-1:0] valid_v,
    input logic [DEPTH-1:0] aok_v,
    input logic [DEPTH-1:0] dok_v,
    input logic [DEPTH-1:0] sent_v
);
    // R9
    offer_live_unsent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (valid_v[mem_idx] && !sent_v[mem_idx]));

    // R7
    own_addr_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> aok_v[mem_idx]);

    // R7
    store_data_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_is_store) |-> dok_v[mem_idx]);

    // R10
    no_mark_without_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_valid && mem_ready) |=> ((sent_v & ~$past(sent_v)) == '0));

    // R11
    accept_marks_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=> sent_v[$past(mem_idx)]);

    // R12
    full_alloc_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !alloc_ready) |=> (count <= $past(count)));
endmodule

bind mem_dispatch_sel mds_chk #(.DEPTH(DEPTH)) u_mds_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .alloc_ready (alloc_ready),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_idx     (mem_idx),
    .mem_is_store(mem_is_store),
    .count       (count),
    .valid_v     (valid_v),
    .aok_v       (aok_v),
    .dok_v       (dok_v),
    .sent_v      (sent_v)
);

// File: tb/test_mem_dispatch_sel.sv
// Scoreboard bench: scenarios push expected accesses, a monitor compares.
module test_mem_dispatch_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [1:0]  alloc_kind = 2'd0;
    logic        alloc_addr_ok = 1'b0;
    logic [15:0] alloc_addr = '0;
    logic        alloc_data_ok = 1'b0;
    logic [31:0] alloc_data = '0;
    logic        alloc_ready;
    logic        res_valid = 1'b0;
    logic [2:0]  res_idx = '0;
    logic        res_addr_en = 1'b0;
    logic [15:0] res_addr = '0;
    logic        res_data_en = 1'b0;
    logic [31:0] res_data = '0;
    logic        pop = 1'b0;
    logic        mem_ready = 1'b0;
    logic        mem_valid;
    logic [2:0]  mem_idx;
    logic        mem_is_store;
    logic [15:0] mem_addr;
    logic [31:0] mem_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [2:0]  idx;
        logic        st;
        logic [15:0] addr;
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t sb [$];

    always #5 clk = ~clk;

    mem_dispatch_sel i_mem_dispatch_sel (.*);

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic alloc(input logic [1:0] k, input logic aok, input logic [15:0] a,
                         input logic dok, input logic [31:0] d);
        alloc_valid = 1'b1; alloc_kind = k; alloc_addr_ok = aok;
        alloc_addr = a; alloc_data_ok = dok; alloc_data = d;
        tick();
        alloc_valid = 1'b0;
    endtask

    task automatic resolve(input logic [2:0] i, input logic ae, input logic [15:0] a,
                           input logic de, input logic [31:0] d);
        res_valid = 1'b1; res_idx = i; res_addr_en = ae; res_addr = a;
        res_data_en = de; res_data = d;
        tick();
        res_valid = 1'b0; res_addr_en = 1'b0; res_data_en = 1'b0;
    endtask

    task automatic pop_n(input int n);
        for (int k = 0; k < n; k++) begin
            pop = 1'b1;
            tick();
        end
        pop = 1'b0;
    endtask

    task automatic expect_acc(input logic [2:0] i, input logic st, input logic [15:0] a,
                              input logic [31:0] d, input string tag);
        exp_t e;
        e.idx = i; e.st = st; e.addr = a; e.data = d; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic run(input int n);
        mem_ready = 1'b1;
        repeat (n) tick();
        mem_ready = 1'b0;
    endtask

    task automatic drained(input string tag);
        check(sb.size() == 0, tag, 64'(sb.size()), 64'd0);
        sb.delete();
    endtask

    // Monitor: every accepted request must match the next expected item
    always @(negedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9 unexpected acceptance", 64'(mem_idx), 64'hFF);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(mem_idx == e.idx, {e.tag, " idx"}, 64'(mem_idx), 64'(e.idx));
                check(mem_is_store == e.st, {e.tag, " is_store"},
                      64'(mem_is_store), 64'(e.st));
                check(mem_addr == e.addr, {e.tag, " addr"}, 64'(mem_addr), 64'(e.addr));
                if (e.st)
                    check(mem_data == e.data, {e.tag, " data"},
                          64'(mem_data), 64'(e.data));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(mem_valid == 1'b0, "R1 mem_valid", 64'(mem_valid), 64'd0);
        check(alloc_ready == 1'b1, "R1 alloc_ready", 64'(alloc_ready), 64'd1);

        // Scenario A: slots 0..3, out-of-order selection, ready low first
        tick();
        alloc(2'd0, 1'b1, 16'h0000, 1'b0, 32'h0);
        alloc(2'd2, 1'b1, 16'h0005, 1'b0, 32'h0);
        alloc(2'd3, 1'b1, 16'h0006, 1'b1, 32'h1111_0006);
        alloc(2'd2, 1'b1, 16'h0007, 1'b0, 32'h0);
        repeat (3) tick();
        @(negedge clk);
        // R10 candidate presented but held
        check(mem_valid == 1'b1, "R10 held valid", 64'(mem_valid), 64'd1);
        check(mem_idx == 3'd1, "R10 held idx", 64'(mem_idx), 64'd1);
        tick();
        expect_acc(3'd1, 1'b0, 16'h0005, 32'h0, "R8 R9 load a5");
        expect_acc(3'd2, 1'b1, 16'h0006, 32'h1111_0006, "R8 R9 store a6");
        expect_acc(3'd3, 1'b0, 16'h0007, 32'h0, "R9 load a7");
        run(4);
        drained("R9 scenario A drained");
        @(negedge clk);
        check(mem_valid == 1'b0, "R11 all sent", 64'(mem_valid), 64'd0);
        tick();
        pop_n(4);

        // Scenario B: open branch at slot 4 gates load at slot 5
        alloc(2'd1, 1'b0, 16'h0000, 1'b0, 32'h0);
        alloc(2'd2, 1'b1, 16'h0008, 1'b0, 32'h0);
        run(2);
        @(negedge clk);
        check(mem_valid == 1'b0, "R2 branch gate", 64'(mem_valid), 64'd0);
        tick();
        expect_acc(3'd5, 1'b0, 16'h0008, 32'h0, "R11 load after branch");
        mem_ready = 1'b1;
        res_valid = 1'b1; res_idx = 3'd4; res_addr_en = 1'b1; res_addr = 16'h0;
        @(negedge clk);
        check(mem_valid == 1'b0, "R11 same-cycle resolve", 64'(mem_valid), 64'd0);
        tick();
        res_valid = 1'b0; res_addr_en = 1'b0;
        tick();
        mem_ready = 1'b0;
        drained("R11 scenario B drained");
        pop_n(2);

        // Scenario C: load at slot 6 without address blocks store at slot 7
        alloc(2'd2, 1'b0, 16'h0000, 1'b0, 32'h0);
        alloc(2'd3, 1'b1, 16'h0009, 1'b1, 32'h2222_0009);
        run(2);
        @(negedge clk);
        check(mem_valid == 1'b0, "R3 load addr gate", 64'(mem_valid), 64'd0);
        tick();
        resolve(3'd6, 1'b1, 16'h0020, 1'b0, 32'h0);
        expect_acc(3'd6, 1'b0, 16'h0020, 32'h0, "R3 load resolved");
        expect_acc(3'd7, 1'b1, 16'h0009, 32'h2222_0009, "R3 store behind");
        run(3);
        drained("R3 scenario C drained");
        pop_n(2);

        // Scenario D: store at slot 0 missing data, wrapped head
        alloc(2'd3, 1'b1, 16'h0030, 1'b0, 32'h0);
        alloc(2'd2, 1'b1, 16'h0031, 1'b0, 32'h0);
        run(2);
        @(negedge clk);
        check(mem_valid == 1'b0, "R4 R7 store data gate", 64'(mem_valid), 64'd0);
        tick();
        resolve(3'd0, 1'b0, 16'h0, 1'b1, 32'hAAAA_5555);
        expect_acc(3'd0, 1'b1, 16'h0030, 32'hAAAA_5555, "R4 R7 store resolved");
        expect_acc(3'd1, 1'b0, 16'h0031, 32'h0, "R4 load behind");
        run(3);
        drained("R4 scenario D drained");
        pop_n(2);

        // Scenario E: same-address chain keeps program order
        alloc(2'd2, 1'b1, 16'h0040, 1'b0, 32'h0);
        alloc(2'd3, 1'b1, 16'h0040, 1'b1, 32'h3333_0040);
        alloc(2'd3, 1'b1, 16'h0040, 1'b1, 32'h4444_0040);
        alloc(2'd2, 1'b1, 16'h0040, 1'b0, 32'h0);
        expect_acc(3'd2, 1'b0, 16'h0040, 32'h0, "R6 first load");
        expect_acc(3'd3, 1'b1, 16'h0040, 32'h3333_0040, "R6 store after load");
        expect_acc(3'd4, 1'b1, 16'h0040, 32'h4444_0040, "R6 store after store");
        expect_acc(3'd5, 1'b0, 16'h0040, 32'h0, "R5 load after stores");
        run(5);
        drained("R5 R6 scenario E drained");
        pop_n(4);

        // Scenario F: full buffer ignores allocate
        for (int k = 0; k < 8; k++) alloc(2'd0, 1'b1, 16'h0, 1'b0, 32'h0);
        @(negedge clk);
        check(alloc_ready == 1'b0, "R12 full", 64'(alloc_ready), 64'd0);
        tick();
        alloc(2'd2, 1'b1, 16'h0050, 1'b0, 32'h0);
        run(2);
        @(negedge clk);
        check(mem_valid == 1'b0, "R12 ignored alloc", 64'(mem_valid), 64'd0);
        tick();
        pop_n(8);
        alloc(2'd2, 1'b1, 16'h0060, 1'b0, 32'h0);
        expect_acc(3'd6, 1'b0, 16'h0060, 32'h0, "R12 R9 slot after wrap");
        run(2);
        drained("R12 scenario F drained");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule